// File: doc/BRIEF.md
# Qualified Low-Pulse Receive Detector

This block sits at the receive input of a UART that runs in a pulse-coded mode. In this mode a logic "0" is sent as a low pulse of 50% duty. For each falling edge on the selected receive line, the block times the low level in sixteenth-bit slots. A slot is one period of an oversampling tick that runs at 16x the bit rate. The block emits a one-clock strobe once the low has lasted a programmable number of slots. Low pulses that are too short are dropped. A high-going glitch of more than one clock inside the low also drops the pulse, even when the total low time would have been long enough.

A loop-back selector chooses the source of the receive path. In normal operation the source is the external pin, passed through a synchronizer. In loop-back the source is the AND of two internal transmit outputs, so the transmit and receive paths can be exercised without external wiring. The selected line is also driven out, for the receive logic downstream.

Top module: `rz_pulse_qualifier`

## Requirements
- R1: With loop-back off, `rx_sel_o` equals `rx_i` delayed by two clock edges (two-stage synchronizer). Transmit inputs have no effect on it.
- R2: With loop-back on, `rx_sel_o` equals `tx_a_i & tx_b_i` in the same cycle, and `rx_i` has no effect on it or on `zero_o`.
- R3: Width code N (0..7) sets a threshold of N+1 tick periods. A low that spans at least N+1 ticks after its falling edge produces a strobe on `zero_o`.
- R4: A low that ends before N+1 ticks have been counted produces no strobe.
- R5: A high level of exactly one clock inside a low being timed is tolerated. Slot counting continues and the pulse can still qualify.
- R6: A high level of two or more consecutive clocks inside a low being timed cancels that pulse, even if the total low time exceeds the threshold. A new qualification starts only on a later falling edge.
- R7: `zero_o` is high for exactly one clock, at most once per falling edge, however long the low lasts.
- R8: `zero_o` rises on the clock edge that follows the cycle in which `tick_i` is high and completes the (N+1)th slot. With `tick_i` held high, code 2 and `rx_i` falling before edge 1, `zero_o` is high only after edge 6.
- R9: While `rst_ni` is low, `zero_o` is 0 and `rx_sel_o` is 1, because the synchronizer presets to the idle level.
- R10: Slots are counted only on cycles where `tick_i` is high. With `tick_i` held low, no low of any length produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | UART clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick at 16x bit rate, one clock wide |
| rx_i | input | 1 | External receive pin, asynchronous |
| tx_a_i | input | 1 | First transmit output, used in loop-back |
| tx_b_i | input | 1 | Second transmit output, used in loop-back |
| lb_en_i | input | 1 | Loop-back enable |
| width_code_i | input | CODE_W | Minimum low width code N, threshold N+1 slots |
| rx_sel_o | output | 1 | Selected receive line |
| zero_o | output | 1 | One-clock strobe: qualified "0" detected |

## Verification
The bench uses the default parameters: a three-bit width code, a two-stage synchronizer and a tolerance of one high clock. The whole code range 0 to 7 can therefore be reached, including the largest threshold. To keep runs short, the bench drives `tick_i` every fourth clock instead of every sixteenth. The pulse lengths in the vector table are chosen with a margin of one tick on either side of each threshold, so the outcome does not depend on tick phase. Directed runs hold the tick high to pin down the exact strobe cycle, and hold it low to show that timing stops without ticks.

// File: rtl/rzq_pkg.sv
package rzq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAL = 2'd1,
    ST_HOLD = 2'd2
  } qual_state_e;
endpackage

// File: rtl/rzq_rx_select.sv
module rzq_rx_select #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tx_a_i,
  input  logic tx_b_i,
  input  logic lb_en_i,
  output logic rx_sel_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lb_src;
  logic [1:0]             age_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= rx_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end
  endgenerate

  // loop-back source stays internal, no sync needed
  assign lb_src   = tx_a_i & tx_b_i;
  assign rx_sel_o = lb_en_i ? lb_src : sync_q[SYNC_STAGES-1];

  // cycles since reset, for history-based checks
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;

  generate
    if (SYNC_STAGES == 2) begin : g_chk2
      AST_EXT_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && !lb_en_i) |-> (rx_sel_o == $past(rx_i, 2))); // R1
    end
  endgenerate

  AST_LB_IGNORES_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && lb_en_i && $past(lb_en_i) && $stable(tx_a_i) && $stable(tx_b_i))
      |-> $stable(rx_sel_o)); // R2
endmodule

// File: rtl/rzq_slot_timer.sv
module rzq_slot_timer #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;

  // slot N+1 completes on the tick seen with N slots already counted
  assign hit_o = !clear_i && tick_i && (cnt_q == code_i);

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !$past(clear_i)) |-> (cnt_q >= $past(cnt_q))); // R3
endmodule

// File: rtl/rzq_qual_fsm.sv
module rzq_qual_fsm
  import rzq_pkg::*;
#(
  parameter int GLITCH_TOL = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic hit_i,
  output logic timer_clr_o,
  output logic zero_o
);
  localparam int HR_W = $clog2(GLITCH_TOL + 2);

  qual_state_e state_q, state_d;
  logic            prev_q;
  logic [HR_W-1:0] hi_run_q, hi_run_d;
  logic            zero_q;
  logic            fall, cancel;

  assign fall   = prev_q & ~sel_i;
  assign cancel = (state_q == ST_QUAL) && sel_i && (hi_run_q == HR_W'(GLITCH_TOL));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (fall) state_d = ST_QUAL;
      ST_QUAL: if (cancel) state_d = ST_IDLE;
               else if (hit_i) state_d = ST_HOLD;
      ST_HOLD: if (sel_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    hi_run_d = '0;
    if (state_q == ST_QUAL && sel_i && hi_run_q != HR_W'(GLITCH_TOL))
      hi_run_d = hi_run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      prev_q   <= 1'b1;
      hi_run_q <= '0;
      zero_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      prev_q   <= sel_i;
      hi_run_q <= hi_run_d;
      zero_q   <= (state_q == ST_QUAL) && hit_i && !cancel;
    end

  assign timer_clr_o = (state_q != ST_QUAL);
  assign zero_o      = zero_q;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |=> !zero_o); // R7

  AST_GLITCH_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUAL && sel_i && prev_q) |=> (!zero_o && state_q == ST_IDLE)); // R6
endmodule

// File: rtl/rz_pulse_qualifier.sv
module rz_pulse_qualifier #(
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_TOL  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              tx_a_i,
  input  logic              tx_b_i,
  input  logic              lb_en_i,
  input  logic [CODE_W-1:0] width_code_i,
  output logic              rx_sel_o,
  output logic              zero_o
);
  logic sel, hit, timer_clr;

  rzq_rx_select #(.SYNC_STAGES(SYNC_STAGES)) u_select (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_i     (rx_i),
    .tx_a_i   (tx_a_i),
    .tx_b_i   (tx_b_i),
    .lb_en_i  (lb_en_i),
    .rx_sel_o (sel)
  );

  rzq_slot_timer #(.CODE_W(CODE_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (timer_clr),
    .tick_i  (tick_i),
    .code_i  (width_code_i),
    .hit_o   (hit)
  );

  rzq_qual_fsm #(.GLITCH_TOL(GLITCH_TOL)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .hit_i       (hit),
    .timer_clr_o (timer_clr),
    .zero_o      (zero_o)
  );

  assign rx_sel_o = sel;

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> $past(tick_i)); // R8

  AST_NO_TICK_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(zero_o) |-> $past(tick_i)); // R10
endmodule

// File: tb/rz_pulse_qualifier_bench.sv
`timescale 1ns/1ps
module rz_pulse_qualifier_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_i = 1'b1, tx_a_i = 1'b1, tx_b_i = 1'b1, lb_en_i = 1'b0;
  logic [2:0] width_code_i = 3'd0;
  logic       rx_sel_o, zero_o;

  int n_chk = 0, n_fail = 0, pulses = 0, tick_mode = 0, tdiv = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rz_pulse_qualifier u_rz_pulse_qualifier (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_i),
    .tx_a_i(tx_a_i), .tx_b_i(tx_b_i), .lb_en_i(lb_en_i),
    .width_code_i(width_code_i), .rx_sel_o(rx_sel_o), .zero_o(zero_o)
  );

  // tick source: 0 every 4th clock, 1 always high, 2 always low
  always @(negedge clk) begin
    if (zero_o) pulses++;
    case (tick_mode)
      0: begin tdiv = (tdiv + 1) % 4; tick_i = (tdiv == 0); end
      1: tick_i = 1'b1;
      default: tick_i = 1'b0;
    endcase
  end

  typedef struct packed {
    logic       lb;
    logic [1:0] src;   // 0 rx, 1 tx_a, 2 tx_b
    logic [2:0] code;
    logic [7:0] a;     // first low, clocks
    logic [7:0] g;     // high gap, clocks
    logic [7:0] b;     // second low, clocks
    logic [3:0] exp;   // expected strobes
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 3'd2, 8'd16, 8'd0, 8'd0,  4'd1, 4'd3},  // R3
    '{1'b0, 2'd0, 3'd2, 8'd8,  8'd0, 8'd0,  4'd0, 4'd4},  // R4
    '{1'b0, 2'd0, 3'd0, 8'd8,  8'd0, 8'd0,  4'd1, 4'd3},  // R3 code 0
    '{1'b0, 2'd0, 3'd7, 8'd36, 8'd0, 8'd0,  4'd1, 4'd3},  // R3 code 7
    '{1'b0, 2'd0, 3'd7, 8'd28, 8'd0, 8'd0,  4'd0, 4'd4},  // R4 code 7
    '{1'b0, 2'd0, 3'd3, 8'd10, 8'd1, 8'd10, 4'd1, 4'd5},  // R5
    '{1'b0, 2'd0, 3'd3, 8'd12, 8'd2, 8'd12, 4'd0, 4'd6},  // R6 cancel
    '{1'b0, 2'd0, 3'd3, 8'd12, 8'd3, 8'd12, 4'd0, 4'd6},  // R6 wider gap
    '{1'b0, 2'd0, 3'd3, 8'd4,  8'd2, 8'd20, 4'd1, 4'd6},  // R6 re-arm
    '{1'b1, 2'd1, 3'd2, 8'd16, 8'd0, 8'd0,  4'd1, 4'd2},  // R2 tx_a
    '{1'b1, 2'd2, 3'd2, 8'd16, 8'd0, 8'd0,  4'd1, 4'd2},  // R2 tx_b
    '{1'b1, 2'd0, 3'd2, 8'd16, 8'd0, 8'd0,  4'd0, 4'd2},  // R2 rx ignored
    '{1'b0, 2'd1, 3'd2, 8'd16, 8'd0, 8'd0,  4'd0, 4'd1},  // R1 tx ignored
    '{1'b0, 2'd0, 3'd1, 8'd80, 8'd0, 8'd0,  4'd1, 4'd7}   // R7 long low
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] src, input logic v);
    case (src)
      2'd0: rx_i = v;
      2'd1: tx_a_i = v;
      default: tx_b_i = v;
    endcase
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    check("R9", int'(zero_o), 0);
    check("R9", int'(rx_sel_o), 1);
    rst_ni = 1'b1;
    idle(10);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int p0;
      v = VECS[i];
      lb_en_i = v.lb;
      width_code_i = v.code;
      idle(8);
      p0 = pulses;
      drive(v.src, 1'b0);
      idle(int'(v.a));
      if (v.g != 0) begin
        drive(v.src, 1'b1);
        idle(int'(v.g));
        drive(v.src, 1'b0);
        idle(int'(v.b));
      end
      drive(v.src, 1'b1);
      idle(24);
      check($sformatf("R%0d vec %0d", v.req, i), pulses - p0, int'(v.exp));
    end
    lb_en_i = 1'b0;
    idle(8);

    // R1: two-edge synchronizer delay
    rx_i = 1'b0;
    idle(1);
    check("R1", int'(rx_sel_o), 1);
    idle(1);
    check("R1", int'(rx_sel_o), 0);
    rx_i = 1'b1;
    idle(24);

    // R2: loop-back path is combinational AND, rx ignored
    lb_en_i = 1'b1;
    tx_a_i = 1'b0;
    #1 check("R2", int'(rx_sel_o), 0);
    tx_a_i = 1'b1; rx_i = 1'b0;
    #1 check("R2", int'(rx_sel_o), 1);
    rx_i = 1'b1;
    lb_en_i = 1'b0;
    idle(8);

    // R8: exact strobe cycle with tick held high, code 2
    tick_mode = 1;
    width_code_i = 3'd2;
    idle(4);
    rx_i = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      idle(1);
      check($sformatf("R8 edge %0d", k), int'(zero_o), (k == 6) ? 1 : 0);
    end
    rx_i = 1'b1;
    idle(12);

    // R10: no ticks, no strobe
    begin
      int p0;
      tick_mode = 2;
      width_code_i = 3'd0;
      idle(4);
      p0 = pulses;
      rx_i = 1'b0;
      idle(60);
      rx_i = 1'b1;
      idle(12);
      check("R10", pulses - p0, 0);
      tick_mode = 0;
    end

    // R9: reset mid-qualification drops strobe and restores idle line
    tick_mode = 1;
    width_code_i = 3'd7;
    rx_i = 1'b0;
    idle(6);
    rst_ni = 1'b0;
    #1 check("R9", int'(zero_o), 0);
    check("R9", int'(rx_sel_o), 1);
    rx_i = 1'b1;
    idle(3);
    rst_ni = 1'b1;
    idle(4);

    finish_run();
  end
endmodule